// File: doc/BRIEF.md
# Double-Word Coprocessor Register Transfer Sequencer

This block moves operands between a 32-bit memory data bus and a file of sixteen 64-bit coprocessor registers. A request names the target register through a 4-bit field of the instruction word. It also says whether the transfer is a load or a store, and whether it is 64 bits wide or one word. A 64-bit transfer takes two consecutive accepted bus beats. The endianness input, sampled when the request is taken, decides which register half travels on the first beat.

A one-word transfer handles one of two data types. A single-precision value lives in the register's upper half. A 32-bit integer lives in the lower half, and an integer load sign-extends into the upper half. Load beats arrive through a valid/ready pair into the block, and store beats leave through a valid/ready pair out of it. A combinational read port lets neighbouring logic see any register. Address generation and the memory itself sit outside.

Top module: `dword_xfer_seq`

## Requirements
- R1: After reset all sixteen registers read zero, `busy` is low, and neither `ld_ready` nor `st_valid` is asserted.
- R2: The target register index is taken from bits 15..12 of `req_word` when a request is accepted. All other bits of `req_word` have no effect.
- R3: In a 64-bit load (`req_wide`=1, `req_store`=0) with `big_endian`=1, the first accepted beat writes bits 63..32 and the second writes bits 31..0. With `big_endian`=0 the order is swapped. `big_endian` is sampled only in the accepting cycle.
- R4: A 64-bit store presents the register halves in the same order as R3: upper half first when big-endian, lower half first otherwise.
- R5: A one-word load with `req_single`=1 writes bits 63..32 and leaves bits 31..0 unchanged.
- R6: A one-word load with `req_single`=0 writes bits 31..0 and fills bits 63..32 with copies of bit 31 of the loaded word.
- R7: A one-word store presents bits 63..32 when `req_single`=1 and bits 31..0 when `req_single`=0.
- R8: A beat counts only in a cycle where valid and ready are both high. `ld_ready` is high only while a load is in progress, and `st_valid` only while a store is in progress.
- R9: `done` is high in the cycle of the final accepted beat: the first beat for a one-word transfer, the second for a 64-bit transfer. `busy` is low from the next cycle on.
- R10: A request raised while `busy` is high is ignored. It changes neither the transfer in progress nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request strobe |
| req_word | input | 32 | Instruction word; bits 15..12 pick the register |
| req_store | input | 1 | 1 = store (register to bus), 0 = load |
| req_wide | input | 1 | 1 = 64-bit two-beat transfer |
| req_single | input | 1 | For one-word transfers: 1 = single-precision (upper half), 0 = integer (lower half) |
| big_endian | input | 1 | Beat ordering for 64-bit transfers |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Final beat accepted this cycle |
| ld_valid | input | 1 | Load beat offered |
| ld_data | input | 32 | Load beat data |
| ld_ready | output | 1 | Load beat accepted when high with ld_valid |
| st_valid | output | 1 | Store beat offered |
| st_data | output | 32 | Store beat data |
| st_ready | input | 1 | Store beat taken when high with st_valid |
| rd_idx | input | 4 | Register read port index |
| rd_data | output | 64 | Register read port data |

## Verification
The hardest situation to reach is a request arriving between the two beats of a 64-bit load. The intruding request names a different register, a different direction and the opposite endianness. The bench creates it by holding `ld_valid` low after the first beat while pulsing `req_valid`. It then confirms that the load still finishes in its original order and that the intruder's register is untouched. Stalled beats come from idle gaps inserted on both bus sides. The endianness input is flipped right after each acceptance, which shows that only the sampled value counts.

// File: rtl/dword_xfer_seq.sv
module dword_xfer_seq #(
  parameter int DW = 32,
  parameter int NREGS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [31:0]     req_word,
  input  logic            req_store,
  input  logic            req_wide,
  input  logic            req_single,
  input  logic            big_endian,
  output logic            busy,
  output logic            done,
  input  logic            ld_valid,
  input  logic [DW-1:0]   ld_data,
  output logic            ld_ready,
  output logic            st_valid,
  output logic [DW-1:0]   st_data,
  input  logic            st_ready,
  input  logic [3:0]      rd_idx,
  output logic [2*DW-1:0] rd_data
);
  localparam int RW = 2 * DW;

  logic [RW-1:0] rf [NREGS];
  logic       beat, c_store, c_wide, c_single, c_be;
  logic [3:0] c_idx;

  wire unused_word = ^{req_word[31:16], req_word[11:0]};

  wire take   = req_valid && !busy;
  wire fire   = c_store ? st_ready : ld_valid;
  wire acc    = busy && fire;
  wire last   = !c_wide || beat;
  wire hi_sel = c_wide ? (c_be ^ beat) : c_single;

  assign ld_ready = busy && !c_store;
  assign st_valid = busy && c_store;
  assign done     = acc && last;
  assign st_data  = hi_sel ? rf[c_idx][RW-1:DW] : rf[c_idx][DW-1:0];
  assign rd_data  = rf[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      beat     <= 1'b0;
      c_store  <= 1'b0;
      c_wide   <= 1'b0;
      c_single <= 1'b0;
      c_be     <= 1'b0;
      c_idx    <= '0;
      for (int i = 0; i < NREGS; i++) rf[i] <= '0;
    end else begin
      if (take) begin
        busy     <= 1'b1;
        beat     <= 1'b0;
        c_store  <= req_store;
        c_wide   <= req_wide;
        c_single <= req_single;
        c_be     <= big_endian;
        c_idx    <= req_word[15:12];
      end
      if (acc) begin
        beat <= 1'b1;
        if (last) busy <= 1'b0;
        if (!c_store) begin
          if (c_wide || c_single) begin
            if (hi_sel) rf[c_idx][RW-1:DW] <= ld_data;
            else        rf[c_idx][DW-1:0]  <= ld_data;
          end else begin
            rf[c_idx] <= {{DW{ld_data[DW-1]}}, ld_data};
          end
        end
      end
    end
  end

  // R9
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R10
  hold_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && $stable(c_idx) && $stable(c_store) && $stable(c_wide) && $stable(c_be)));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fire) |=> (busy && $stable(beat)));

  // R6
  sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !c_store && !c_wide && !c_single) |=>
      (rf[$past(c_idx)] == {{DW{$past(ld_data[DW-1])}}, $past(ld_data)}));

  // R5
  single_keep_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !c_store && !c_wide && c_single) |=>
      (rf[$past(c_idx)][DW-1:0] == $past(rf[c_idx][DW-1:0])));
endmodule

// File: tb/dword_xfer_seq_tb.sv
`timescale 1ns/1ps
module dword_xfer_seq_tb;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_store = 0, req_wide = 0, req_single = 0, big_endian = 0;
  logic [31:0] req_word = 0;
  logic busy, done, ld_ready, st_valid;
  logic ld_valid = 0, st_ready = 0;
  logic [31:0] ld_data = 0, st_data;
  logic [3:0] rd_idx = 0;
  logic [63:0] rd_data;
  logic [63:0] mdl [16];
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  dword_xfer_seq u_dut (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic start(bit st, bit wide, bit single, int idx, bit be);
    @(negedge clk);
    req_valid = 1; req_store = st; req_wide = wide; req_single = single;
    big_endian = be;
    req_word = {16'hA5C3, idx[3:0], 12'h9E7};
    @(negedge clk);
    req_valid = 0; big_endian = ~be; req_word = 32'hFFFF_FFFF;
    chk("R1/R9 busy after accept", busy, 1);
  endtask

  task automatic ld_beat(logic [31:0] d, bit exp_done);
    ld_valid = 1; ld_data = d; #0.5;
    chk("R8 ld_ready", ld_ready, 1);
    chk("R8 st_valid low in load", st_valid, 0);
    chk("R9 done on load beat", done, exp_done);
    @(negedge clk); ld_valid = 0;
  endtask

  task automatic st_beat(logic [31:0] exp, bit exp_done);
    st_ready = 1; #0.5;
    chk("R8 st_valid", st_valid, 1);
    chk("R8 ld_ready low in store", ld_ready, 0);
    chk("R4/R7 st_data", st_data, exp);
    chk("R9 done on store beat", done, exp_done);
    @(negedge clk); st_ready = 0;
  endtask

  task automatic rd_chk(string tag, int idx);
    rd_idx = idx[3:0]; #0.5;
    chk(tag, rd_data, mdl[idx]);
  endtask

  task automatic idle_chk();
    chk("R9 busy low after done", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 busy", busy, 0);
    chk("R1 ld_ready", ld_ready, 0);
    chk("R1 st_valid", st_valid, 0);
    for (int i = 0; i < 16; i++) rd_chk("R1 reg zero", i);

    // R2 R3 R4: wide loads/stores, both endians, all registers
    for (int be = 0; be < 2; be++) begin
      for (int i = 0; i < 16; i++) begin
        logic [31:0] w0, w1;
        w0 = 32'h1000_0000 + i * 32'h0101_0011 + be * 32'h0800_0000;
        w1 = ~w0 ^ (i << 7);
        start(0, 1, 0, i, be[0]);
        ld_beat(w0, 0);
        if (i % 3 == 0) begin
          @(negedge clk);
          chk("R8 stall keeps busy", busy, 1);
        end
        ld_beat(w1, 1);
        mdl[i] = be[0] ? {w0, w1} : {w1, w0};
        idle_chk();
        rd_chk("R3 wide load", i);
      end
      for (int i = 0; i < 16; i++) begin
        start(1, 1, 0, i, be[0]);
        if (i % 4 == 1) @(negedge clk);
        st_beat(be[0] ? mdl[i][63:32] : mdl[i][31:0], 0);
        st_beat(be[0] ? mdl[i][31:0] : mdl[i][63:32], 1);
        idle_chk();
      end
    end

    // R5 R6 R7: one-word transfers
    for (int i = 0; i < 16; i++) begin
      logic [31:0] f, n;
      f = 32'h3F80_0000 + i;
      n = (i % 2) ? (32'h8000_1234 + i) : (32'h0000_7654 + i);
      start(0, 0, 1, i, 0);
      ld_beat(f, 1);
      mdl[i][63:32] = f;
      idle_chk();
      rd_chk("R5 single load", i);
      start(1, 0, 1, i, 1);
      st_beat(f, 1);
      idle_chk();
      start(0, 0, 0, (i + 5) % 16, 1);
      ld_beat(n, 1);
      mdl[(i + 5) % 16] = {{32{n[31]}}, n};
      idle_chk();
      rd_chk("R6 int load sext", (i + 5) % 16);
      start(1, 0, 0, (i + 5) % 16, 0);
      st_beat(n, 1);
      idle_chk();
      rd_chk("R5 single load keeps lower", i);
    end

    // R10: intruding request mid wide load
    start(0, 1, 0, 2, 1);
    ld_beat(32'hCAFE_0001, 0);
    @(negedge clk);
    req_valid = 1; req_store = 1; req_wide = 0; req_single = 0;
    big_endian = 0; req_word = {16'h0, 4'd9, 12'h0};
    @(negedge clk);
    req_valid = 0;
    #0.5;
    chk("R10 still load", ld_ready, 1);
    chk("R10 no store", st_valid, 0);
    ld_beat(32'hBEEF_0002, 1);
    mdl[2] = {32'hCAFE_0001, 32'hBEEF_0002};
    idle_chk();
    rd_chk("R10 original target", 2);
    rd_chk("R10 intruder untouched", 9);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule